// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the instruction fetch stream of a processor and raises a breakpoint event when a fetch address hits one of its programmed comparators. It holds a set of comparator slots (four by default). Each slot stores a word address, its own enable and a halfword-select field. A unit-wide enable, which changes only through a keyed write, gates every slot. Software reaches the control word, the comparator words and a block of constant identification words at the top of a 4 KB window through a simple word-addressed register port. Reads of that port are combinational.

Configuration state is reset by a debug-domain reset. The event output stage is reset by the system reset, so a system reset leaves programmed breakpoints in place. An event is a single-cycle pulse in the cycle after the qualifying fetch. It carries the index of the lowest-numbered comparator that hit. Halting the core and any bus fabric lie outside this block.

Top module: `fetch_bkpt_unit`

## Requirements
- R1: The control word (word index 0) reads bit 0 = unit enable, bit 1 = 0, bits 7:4 = comparator count (4), and all other bits 0; the reset value is 0x00000040.
- R2: A write to the control word changes the unit enable to write-data bit 0 only when write-data bit 1 is 1; a control write with bit 1 clear leaves the enable unchanged.
- R3: Comparator k sits at word index 2+k (byte offsets 0x008, 0x00C, 0x010, 0x014). Bit 0 is the comparator enable, bits 28:2 the compare address and bits 31:30 the halfword select. Bits 29 and 1 read 0.
- R4: The debug reset clears the unit enable, every comparator enable, every halfword select (to 00) and every compare address.
- R5: A comparator produces a hit only when both the unit enable and its own enable are 1.
- R6: A hit needs fetch address bits 28:2 equal to the stored compare address and bits 31:29 all zero. Fetches in any higher region never hit.
- R7: Halfword select encoding: 00 never hits, 01 hits only when fetch address bit 1 is 0, 10 hits only when bit 1 is 1, and 11 hits for either value.
- R8: The second-halfword flag does not suppress a hit: a matching fetch flagged as the second halfword of a 32-bit instruction raises an event.
- R9: The event output is high for exactly the one cycle after a clock edge that samples a valid matching fetch. A fetch with the valid qualifier low raises no event.
- R10: When several comparators hit on the same fetch, the reported index is the lowest-numbered comparator that hit. The index reads 0 when no event is raised.
- R11: Identification words at byte offsets 0xFD0..0xFFC (word indices 0x3F4..0x3FF) read, in offset order, 0x04, 0x00, 0x00, 0x00, 0x0B, 0xB0, 0x0B, 0x00, 0x0D, 0xE0, 0x05, 0xB1 in bits 7:0, with bits 31:8 zero.
- R12: Unmapped word indices read zero. Writes to read-only fields, to identification words or to unmapped indices change no readable state.
- R13: The system reset holds the event output low but leaves the unit enable and comparator configuration intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dbg_rst_n | input | 1 | Debug-domain reset, active low, clears configuration |
| sys_rst_n | input | 1 | System reset, active low, clears event output stage |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Access is a write when 1 |
| reg_word | input | 10 | Word index within the 4 KB window (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when not selected |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| fetch_hi_half | input | 1 | Fetch is the second halfword of a 32-bit instruction |
| bkpt_evt | output | 1 | One-cycle breakpoint event |
| bkpt_idx | output | 2 | Index of the lowest comparator that hit |

## Verification
The bench sweeps every halfword-select code on every comparator against both values of address bit 1 and both values of the second-halfword flag. A swapped select encoding or a flag that vetoes hits would show up there as missing or spurious events. It fetches next to each programmed address and in the upper address region, which catches a comparison that is too narrow or ignores bits 31:29. It walks all fifteen enable patterns over four identical comparators, so a priority encoder that picks the highest index fails. It also probes the keyed control write with the key clear, and a system reset that wipes configuration. A design that does either would leave the enable changed after an unkeyed write, or lose breakpoints after the reset.

// File: rtl/fbk_pkg.sv
package fbk_pkg;

   // Word index space of the 4 KB register window
   localparam int REG_WW = 10;

   localparam logic [REG_WW-1:0] CTRL_WORD    = 10'h000;
   localparam logic [REG_WW-1:0] CMP_BASE     = 10'h002;
   localparam logic [REG_WW-1:0] ID_BASE      = 10'h3F4;
   localparam int                ID_WORDS     = 12;

   // Halfword select codes held in bits 31:30 of a comparator word
   typedef enum logic [1:0] {
      HS_NONE = 2'b00,
      HS_LOW  = 2'b01,
      HS_HIGH = 2'b10,
      HS_BOTH = 2'b11
   } half_sel_e;

   // Constant identification byte for id word k (k counted from ID_BASE)
   function automatic logic [7:0] id_byte(input logic [3:0] k);
      case (k)
         4'd0:    id_byte = 8'h04;
         4'd4:    id_byte = 8'h0B;
         4'd5:    id_byte = 8'hB0;
         4'd6:    id_byte = 8'h0B;
         4'd8:    id_byte = 8'h0D;
         4'd9:    id_byte = 8'hE0;
         4'd10:   id_byte = 8'h05;
         4'd11:   id_byte = 8'hB1;
         default: id_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/fbk_ctrl_reg.sv
module fbk_ctrl_reg #(
   parameter int NUM_CMP = 4
) (
   input  logic        clk,
   input  logic        dbg_rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic        unit_en,
   output logic [31:0] rdata
);

   localparam logic [3:0] CNT_CODE = 4'(NUM_CMP);

   if (NUM_CMP < 2 || NUM_CMP > 15) begin : g_bad_count
      $error("fbk_ctrl_reg: NUM_CMP must lie in 2..15");
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata[31:2];

   always_ff @(posedge clk or negedge dbg_rst_n) begin
      if (!dbg_rst_n)
         unit_en <= 1'b0;
      else if (wr_en && wdata[1])
         unit_en <= wdata[0];
   end

   always_comb begin
      rdata      = '0;
      rdata[7:4] = CNT_CODE;
      rdata[0]   = unit_en;
   end

   // R2
   key_gate_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      (wr_en && !wdata[1]) |=> $stable(unit_en));

   // R2
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      !wr_en |=> $stable(unit_en));

endmodule

// File: rtl/fbk_comparator.sv
module fbk_comparator
   import fbk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CMP_HI = 28,
   parameter int CMP_LO = 2
) (
   input  logic              clk,
   input  logic              dbg_rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   input  logic              unit_en,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [31:0]       rdata,
   output logic              hit
);

   localparam int CW = CMP_HI - CMP_LO + 1;

   if (CMP_LO < 2 || CMP_HI > 28 || ADDR_W < CMP_HI + 2 || CMP_HI < CMP_LO) begin : g_bad_field
      $error("fbk_comparator: compare field must sit inside bits 28:2 below ADDR_W");
   end

   logic          en_q;
   half_sel_e     sel_q;
   logic [CW-1:0] comp_q;

   logic unused_bits;
   assign unused_bits = ^{wdata[29], wdata[1], fetch_addr[0], wdata};

   always_ff @(posedge clk or negedge dbg_rst_n) begin
      if (!dbg_rst_n) begin
         en_q   <= 1'b0;
         sel_q  <= HS_NONE;
         comp_q <= '0;
      end else if (wr_en) begin
         en_q   <= wdata[0];
         sel_q  <= half_sel_e'(wdata[31:30]);
         comp_q <= wdata[CMP_HI:CMP_LO];
      end
   end

   always_comb begin
      rdata                = '0;
      rdata[31:30]         = sel_q;
      rdata[CMP_HI:CMP_LO] = comp_q;
      rdata[0]             = en_q;
   end

   logic region_ok;
   logic word_eq;
   logic half_ok;

   assign region_ok = (fetch_addr[ADDR_W-1:CMP_HI+1] == '0);
   assign word_eq   = (fetch_addr[CMP_HI:CMP_LO] == comp_q);

   always_comb begin
      case (sel_q)
         HS_LOW:  half_ok = ~fetch_addr[1];
         HS_HIGH: half_ok =  fetch_addr[1];
         HS_BOTH: half_ok = 1'b1;
         default: half_ok = 1'b0;
      endcase
   end

   assign hit = unit_en & en_q & region_ok & word_eq & half_ok;

   // R4
   cfg_reset_chk: assert property (@(posedge clk)
      $rose(dbg_rst_n) |-> (!en_q && sel_q == HS_NONE && comp_q == '0));

   // R5
   hit_gate_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      hit |-> unit_en);

endmodule

// File: rtl/fbk_prio_enc.sv
module fbk_prio_enc #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  hits,
   output logic          any,
   output logic [IW-1:0] idx
);

   if (IW < $clog2(N)) begin : g_bad_width
      $error("fbk_prio_enc: IW too narrow for N");
   end

   always_comb begin
      idx = '0;
      for (int j = N - 1; j >= 0; j--) begin
         if (hits[j]) idx = IW'(j);
      end
   end

   assign any = |hits;

   always_comb begin
      // R10
      if (any) begin
         lowest_pick_chk: assert (hits[idx]);
      end
   end

endmodule

// File: rtl/fbk_id_rom.sv
module fbk_id_rom
   import fbk_pkg::*;
(
   input  logic [REG_WW-1:0] word,
   output logic [31:0]       rdata
);

   logic [REG_WW-1:0] rel;
   assign rel = word - ID_BASE;

   always_comb begin
      rdata = '0;
      if (word >= ID_BASE && rel < REG_WW'(ID_WORDS))
         rdata[7:0] = id_byte(rel[3:0]);
   end

endmodule

// File: rtl/fetch_bkpt_unit.sv
module fetch_bkpt_unit
   import fbk_pkg::*;
#(
   parameter int NUM_CMP = 4,
   parameter int ADDR_W  = 32,
   parameter int CMP_HI  = 28,
   parameter int CMP_LO  = 2,
   parameter int IDX_W   = 2
) (
   input  logic              clk,
   input  logic              dbg_rst_n,
   input  logic              sys_rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [REG_WW-1:0] reg_word,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_hi_half,
   output logic              bkpt_evt,
   output logic [IDX_W-1:0]  bkpt_idx
);

   if (IDX_W < $clog2(NUM_CMP)) begin : g_bad_idx
      $error("fetch_bkpt_unit: IDX_W too narrow for NUM_CMP");
   end

   logic               wr_strobe;
   logic               ctrl_wr;
   logic               unit_en;
   logic [31:0]        ctrl_rd;
   logic [31:0]        id_rd;
   logic [NUM_CMP-1:0] cmp_hit;
   logic [31:0]        cmp_rd [NUM_CMP];
   logic               any_hit;
   logic [IDX_W-1:0]   hit_idx;

   assign wr_strobe = reg_sel & reg_wr;
   assign ctrl_wr   = wr_strobe && (reg_word == CTRL_WORD);

   fbk_ctrl_reg #(.NUM_CMP(NUM_CMP)) u_ctrl (
      .clk       (clk),
      .dbg_rst_n (dbg_rst_n),
      .wr_en     (ctrl_wr),
      .wdata     (reg_wdata),
      .unit_en   (unit_en),
      .rdata     (ctrl_rd)
   );

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      logic slot_wr;
      assign slot_wr = wr_strobe && (reg_word == CMP_BASE + REG_WW'(g));

      fbk_comparator #(
         .ADDR_W (ADDR_W),
         .CMP_HI (CMP_HI),
         .CMP_LO (CMP_LO)
      ) u_slot (
         .clk        (clk),
         .dbg_rst_n  (dbg_rst_n),
         .wr_en      (slot_wr),
         .wdata      (reg_wdata),
         .unit_en    (unit_en),
         .fetch_addr (fetch_addr),
         .rdata      (cmp_rd[g]),
         .hit        (cmp_hit[g])
      );
   end

   fbk_prio_enc #(.N(NUM_CMP), .IW(IDX_W)) u_prio (
      .hits (cmp_hit),
      .any  (any_hit),
      .idx  (hit_idx)
   );

   fbk_id_rom u_id (
      .word  (reg_word),
      .rdata (id_rd)
   );

   always_comb begin
      reg_rdata = id_rd;
      if (reg_word == CTRL_WORD)
         reg_rdata = ctrl_rd;
      for (int k = 0; k < NUM_CMP; k++) begin
         if (reg_word == CMP_BASE + REG_WW'(k))
            reg_rdata = cmp_rd[k];
      end
      if (!reg_sel)
         reg_rdata = '0;
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         bkpt_evt <= 1'b0;
         bkpt_idx <= '0;
      end else begin
         bkpt_evt <= fetch_valid & any_hit;
         bkpt_idx <= (fetch_valid & any_hit) ? hit_idx : '0;
      end
   end

   // R9
   evt_source_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      bkpt_evt |-> $past(fetch_valid));

   // R5
   evt_enable_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      bkpt_evt |-> $past(unit_en));

   // R6
   high_region_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (fetch_valid && fetch_addr[ADDR_W-1:CMP_HI+1] != '0) |=> !bkpt_evt);

   // R8
   hi_half_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (fetch_valid && fetch_hi_half && any_hit) |=> bkpt_evt);

   // R10
   idx_idle_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !bkpt_evt |-> (bkpt_idx == '0));

endmodule

// File: tb/fetch_bkpt_unit_tb.sv
module fetch_bkpt_unit_tb;

   logic        clk = 1'b0;
   logic        dbg_rst_n = 1'b0;
   logic        sys_rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [9:0]  reg_word = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_hi_half = 1'b0;
   logic        bkpt_evt;
   logic [1:0]  bkpt_idx;

   int n_chk = 0;
   int n_err = 0;

   // bench model of the configuration
   logic        m_ue;
   logic        m_en   [4];
   logic [1:0]  m_sel  [4];
   logic [26:0] m_comp [4];

   always #2.5 clk = ~clk;

   fetch_bkpt_unit u_dut (
      .clk           (clk),
      .dbg_rst_n     (dbg_rst_n),
      .sys_rst_n     (sys_rst_n),
      .reg_sel       (reg_sel),
      .reg_wr        (reg_wr),
      .reg_word      (reg_word),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .fetch_valid   (fetch_valid),
      .fetch_addr    (fetch_addr),
      .fetch_hi_half (fetch_hi_half),
      .bkpt_evt      (bkpt_evt),
      .bkpt_idx      (bkpt_idx)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      m_ue = 1'b0;
      for (int i = 0; i < 4; i++) begin
         m_en[i] = 1'b0; m_sel[i] = 2'b00; m_comp[i] = '0;
      end
   endtask

   task automatic wr(input logic [9:0] w, input logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_word = w; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [9:0] w, output logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_word = w;
      #1 d = reg_rdata;
      reg_sel = 1'b0;
   endtask

   task automatic set_unit(input logic en);
      wr(10'h000, {30'd0, 1'b1, en});
      m_ue = en;
   endtask

   task automatic prog(input int i, input logic [1:0] s, input logic [26:0] c, input logic en);
      wr(10'(2 + i), {s, 1'b0, c, 1'b0, en});
      m_sel[i] = s; m_comp[i] = c; m_en[i] = en;
   endtask

   function automatic logic [3:0] model_hits(input logic [31:0] a);
      logic [3:0] h;
      for (int i = 0; i < 4; i++) begin
         logic hs;
         case (m_sel[i])
            2'b01:   hs = ~a[1];
            2'b10:   hs =  a[1];
            2'b11:   hs = 1'b1;
            default: hs = 1'b0;
         endcase
         h[i] = m_ue && m_en[i] && a[31:29] == 3'b000 && a[28:2] == m_comp[i] && hs;
      end
      return h;
   endfunction

   task automatic fetch_chk(input logic [31:0] a, input logic hi, input string tag);
      logic [3:0] h;
      logic [1:0] ei;
      h  = model_hits(a);
      ei = 2'd0;
      for (int j = 3; j >= 0; j--) if (h[j]) ei = 2'(j);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a; fetch_hi_half = hi;
      @(negedge clk);
      fetch_valid = 1'b0;
      check({tag, " evt"}, {31'd0, bkpt_evt}, {31'd0, |h});
      check({tag, " idx"}, {30'd0, bkpt_idx}, {30'd0, ei});
      @(negedge clk);
      check({tag, " R9 pulse width"}, {31'd0, bkpt_evt}, 32'd0);
   endtask

   function automatic logic [7:0] exp_id(input int k);
      case (k)
         0: return 8'h04;  4: return 8'h0B;  5: return 8'hB0;  6: return 8'h0B;
         8: return 8'h0D;  9: return 8'hE0; 10: return 8'h05; 11: return 8'hB1;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [31:0] cmp_word(input int i);
      return {m_sel[i], 1'b0, m_comp[i], 1'b0, m_en[i]};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] d;
      model_clear();
      repeat (3) @(negedge clk);
      dbg_rst_n = 1'b1; sys_rst_n = 1'b1;

      // R1 reset value, R4 comparators cleared
      rd(10'h000, d); check("R1 ctrl reset", d, 32'h40);
      for (int i = 0; i < 4; i++) begin
         rd(10'(2 + i), d); check("R4 cmp reset", d, 32'h0);
      end
      check("R9 evt idle after reset", {31'd0, bkpt_evt}, 32'd0);

      // R11 identification words
      for (int k = 0; k < 12; k++) begin
         rd(10'(10'h3F4 + k), d); check("R11 id word", d, {24'd0, exp_id(k)});
      end

      // R12 unmapped reads
      rd(10'h001, d); check("R12 unmapped 0x004", d, 32'h0);
      rd(10'h006, d); check("R12 unmapped 0x018", d, 32'h0);
      rd(10'h3F3, d); check("R12 unmapped 0xFCC", d, 32'h0);
      rd(10'h100, d); check("R12 unmapped 0x400", d, 32'h0);

      // R2 keyed control writes
      wr(10'h000, 32'h1);        rd(10'h000, d); check("R2 no key ignored", d, 32'h40);
      wr(10'h000, 32'h3);        rd(10'h000, d); check("R2 keyed enable", d, 32'h41);
      wr(10'h000, 32'h0);        rd(10'h000, d); check("R2 no key keeps enable", d, 32'h41);
      wr(10'h000, 32'hFFFFFFFF); rd(10'h000, d); check("R12 RO fields in ctrl", d, 32'h41);
      wr(10'h000, 32'h2);        rd(10'h000, d); check("R2 keyed disable", d, 32'h40);
      m_ue = 1'b0;

      // R12 writes to id / unmapped words
      wr(10'h3F4, 32'hFFFFFFFF); rd(10'h3F4, d); check("R12 id write ignored", d, 32'h04);
      wr(10'h007, 32'hFFFFFFFF); rd(10'h007, d); check("R12 unmapped write", d, 32'h0);
      for (int i = 0; i < 4; i++) begin
         rd(10'(2 + i), d); check("R12 cmp untouched", d, 32'h0);
      end

      // R3 field layout and reserved bits
      for (int i = 0; i < 4; i++) begin
         wr(10'(2 + i), 32'hFFFFFFFF);
         rd(10'(2 + i), d); check("R3 cmp layout", d, 32'hDFFFFFFD);
         prog(i, 2'b00, 27'd0, 1'b0);
      end

      // R5 / R6 / R7 / R8 sweep
      set_unit(1'b1);
      for (int i = 0; i < 4; i++) begin
         for (int s = 0; s < 4; s++) begin
            logic [26:0] c;
            c = 27'h0012340 + 27'(i * 37);
            for (int o = 0; o < 4; o++) if (o != i) m_en[o] = 1'b0;
            prog(i, 2'(s), c, 1'b1);
            rd(10'(2 + i), d); check("R3 cmp readback", d, cmp_word(i));
            for (int b = 0; b < 2; b++) begin
               for (int hh = 0; hh < 2; hh++) begin
                  fetch_chk({3'b000, c, 1'(b), 1'b0}, 1'(hh), "R7 R8 halfword sweep");
               end
            end
            fetch_chk({3'b001, c, 2'b10}, 1'b0, "R6 region bit 29");
            fetch_chk({3'b100, c, 2'b00}, 1'b0, "R6 region bit 31");
            fetch_chk({3'b000, c + 27'd1, 2'b10}, 1'b0, "R6 neighbour word");
         end
         prog(i, 2'b11, 27'h0012340 + 27'(i * 37), 1'b0);
         fetch_chk({3'b000, 27'h0012340 + 27'(i * 37), 2'b00}, 1'b0, "R5 comparator disabled");
      end

      // R5 unit disable
      prog(0, 2'b11, 27'h0000100, 1'b1);
      fetch_chk({3'b000, 27'h0000100, 2'b00}, 1'b0, "R5 both enabled");
      set_unit(1'b0);
      fetch_chk({3'b000, 27'h0000100, 2'b00}, 1'b0, "R5 unit disabled");
      set_unit(1'b1);

      // R10 priority across all enable patterns
      for (int m = 1; m < 16; m++) begin
         for (int i = 0; i < 4; i++) prog(i, 2'b11, 27'h0055500, m[i]);
         fetch_chk({3'b000, 27'h0055500, 2'b10}, 1'b1, "R10 lowest index");
      end

      // R9 valid low raises nothing
      @(negedge clk);
      fetch_valid = 1'b0; fetch_addr = {3'b000, 27'h0055500, 2'b00};
      @(negedge clk);
      check("R9 no valid no event", {31'd0, bkpt_evt}, 32'd0);

      // R9 back-to-back fetches give one pulse each
      @(negedge clk);
      fetch_valid = 1'b1;
      @(negedge clk);
      check("R9 back-to-back first", {31'd0, bkpt_evt}, 32'd1);
      @(negedge clk);
      fetch_valid = 1'b0;
      check("R9 back-to-back second", {31'd0, bkpt_evt}, 32'd1);
      @(negedge clk);
      check("R9 back-to-back end", {31'd0, bkpt_evt}, 32'd0);

      // R13 system reset keeps configuration
      @(negedge clk);
      sys_rst_n = 1'b0; fetch_valid = 1'b1;
      @(negedge clk);
      check("R13 evt held in sys reset", {31'd0, bkpt_evt}, 32'd0);
      fetch_valid = 1'b0; sys_rst_n = 1'b1;
      rd(10'h000, d); check("R13 ctrl kept", d, 32'h41);
      rd(10'h002, d); check("R13 cmp kept", d, cmp_word(0));
      fetch_chk({3'b000, 27'h0055500, 2'b00}, 1'b0, "R13 still fires");

      // R4 debug reset mid-run
      @(negedge clk);
      dbg_rst_n = 1'b0;
      @(negedge clk);
      dbg_rst_n = 1'b1;
      model_clear();
      rd(10'h000, d); check("R4 ctrl after dbg reset", d, 32'h40);
      for (int i = 0; i < 4; i++) begin
         rd(10'(2 + i), d); check("R4 cmp after dbg reset", d, 32'h0);
      end
      fetch_chk({3'b000, 27'h0055500, 2'b00}, 1'b0, "R4 no hit after dbg reset");

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule